// File: doc/BRIEF.md
# ATA Security-Unlock Password Sniffer

This block watches a parallel ATA host-to-drive interface in PIO mode and never drives it. Every bus input first passes through a synchronizer. When the host releases its write strobe, the block uses the two chip selects and the three device-address lines to work out which task-file register was written. It then keeps a record of that write.

When the host writes the security-unlock opcode to the command register, the block arms itself. It drops the first data-register word that follows, because that word is a control word. It then collects the next sixteen 16-bit data-register words as a 32-byte password. After the final word it copies the whole password to its output in one step and raises a single-cycle valid pulse. The output keeps that value until the next capture completes.

Any other command written while a capture is in progress cancels it. Writes to other registers and any read cycles do not affect the capture. The data width, password length, number of skipped control words, synchronizer depth, byte order and opcode are all parameters.

Top module: `ata_unlock_sniffer`

## Requirements
- R1: After reset, `password_valid` and `log_valid` are 0, `password` is all zeros, and `log_addr`/`log_data` are zero.
- R2: A write is a command write when `cs0_n`=0, `cs1_n`=1 and `da`=3'b111. Only `dd[7:0]` is the opcode. An opcode of 8'hF2 arms a capture whatever the value of `dd[15:8]`.
- R3: Once armed, the first data-register write (`cs0_n`=0, `cs1_n`=1, `da`=3'b000) is discarded. The next 16 data words w0..w15 form the password, with byte 2k = wk[7:0] and byte 2k+1 = wk[15:8]. Byte i is placed at `password[8i+7:8i]`.
- R4: After the 16th password word, `password_valid` is high for exactly one clock cycle. `password` changes only in that cycle and holds its value until the next capture completes.
- R5: A command write with an opcode other than 8'hF2 before the capture completes cancels it, and later data words give no pulse. A command write of 8'hF2 during a capture restarts the sequence, including the discarded control word. Data words written while the block is not armed are ignored.
- R6: Writes to any other selected register leave the capture state unchanged. This covers the other task-file registers (`cs0_n`=0, `cs1_n`=1, `da` not 0 or 7) and the control-block registers (`cs1_n`=0, `cs0_n`=1, for example device control at `da`=3'b110).
- R7: Read strobes (`dior_n` low) never count as writes. A `diow_n` release while `dior_n` is asserted is ignored.
- R8: Each accepted write sets `log_valid`. It loads `log_addr` = {`cs1_n`, `cs0_n`, `da`} as sampled and `log_data` = the written value. For every register except the data register, `log_data[15:8]` is 0.
- R9: A write with both chip selects negated or both asserted selects no register. It is neither logged nor used.
- R10: Each write is taken once, at the release (rising edge) of `diow_n`. It uses the `dd`, `cs` and `da` values sampled one cycle before the release was seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sniffer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dd | input | 16 | ATA data bus |
| cs0_n | input | 1 | Active-low chip select, command block |
| cs1_n | input | 1 | Active-low chip select, control block |
| da | input | 3 | Device address lines |
| diow_n | input | 1 | Active-low host write strobe |
| dior_n | input | 1 | Active-low host read strobe |
| password | output | 256 | Captured password, byte i at bits 8i+7:8i |
| password_valid | output | 1 | One-cycle pulse when a password is complete |
| log_addr | output | 5 | {cs1_n, cs0_n, da} of the last accepted write |
| log_data | output | 16 | Value of the last accepted write |
| log_valid | output | 1 | At least one write has been accepted |

## Verification
The assertions assume that each write strobe stays low for at least one sampled cycle. They also assume that `dd`, `cs` and `da` are stable from before the strobe falls until the release has passed the synchronizer, and that a read and a write never overlap except on purpose. The bench enforces this by setting the address and data two cycles before each strobe, holding the strobe low for three cycles, and keeping the address four cycles after release before returning the selects to idle. The overlapping read-and-write case is generated only by a separate task, so that it tests only the rule that such a release is ignored.

// File: rtl/ata_snoop_pkg.sv
package ata_snoop_pkg;

   localparam int ADDR_W = 5;
   localparam logic [2:0] DA_DATA = 3'b000;
   localparam logic [2:0] DA_CMD  = 3'b111;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_DATA = 2'd1,
      RK_CMD  = 2'd2,
      RK_AUX  = 2'd3
   } reg_kind_e;

   typedef enum logic [1:0] {
      CAP_IDLE    = 2'd0,
      CAP_SKIP    = 2'd1,
      CAP_COLLECT = 2'd2
   } cap_state_e;

   function automatic reg_kind_e classify(input logic cs1_n, input logic cs0_n,
                                          input logic [2:0] da);
      if (cs1_n && !cs0_n) begin
         if (da == DA_DATA) return RK_DATA;
         if (da == DA_CMD)  return RK_CMD;
         return RK_AUX;
      end
      if (!cs1_n && cs0_n) return RK_AUX;
      return RK_NONE;
   endfunction

endpackage

// File: rtl/ata_snoop_sync.sv
module ata_snoop_sync #(
   parameter int          W         = 8,
   parameter int          STAGES    = 2,
   parameter logic [W-1:0] RESET_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);

   initial begin
      assert (STAGES >= 2) else $error("ata_snoop_sync: STAGES must be at least 2");
      assert (W >= 1)      else $error("ata_snoop_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= RESET_VAL;
               else        chain_q[gi] <= d_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= RESET_VAL;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/ata_snoop_decode.sv
module ata_snoop_decode
   import ata_snoop_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] dd_s,
   input  logic              cs1_n_s,
   input  logic              cs0_n_s,
   input  logic [2:0]        da_s,
   input  logic              diow_n_s,
   input  logic              dior_n_s,
   output logic              ev_valid,
   output reg_kind_e         ev_kind,
   output logic [ADDR_W-1:0] ev_addr,
   output logic [DATA_W-1:0] ev_data
);

   initial begin
      assert (DATA_W >= 8 && DATA_W % 8 == 0)
         else $error("ata_snoop_decode: DATA_W must be a multiple of 8");
   end

   logic              w_prev_q, r_prev_q, cs1_prev_q, cs0_prev_q;
   logic [2:0]        da_prev_q;
   logic [DATA_W-1:0] dd_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_prev_q   <= 1'b1;
         r_prev_q   <= 1'b1;
         cs1_prev_q <= 1'b1;
         cs0_prev_q <= 1'b1;
         da_prev_q  <= '0;
         dd_prev_q  <= '0;
      end else begin
         w_prev_q   <= diow_n_s;
         r_prev_q   <= dior_n_s;
         cs1_prev_q <= cs1_n_s;
         cs0_prev_q <= cs0_n_s;
         da_prev_q  <= da_s;
         dd_prev_q  <= dd_s;
      end
   end

   logic              release_seen;
   reg_kind_e         kind_c;
   logic [DATA_W-1:0] narrow_c;

   assign release_seen = !w_prev_q && diow_n_s && r_prev_q;
   assign kind_c       = classify(cs1_prev_q, cs0_prev_q, da_prev_q);

   generate
      if (DATA_W > 8) begin : g_mask
         assign narrow_c = {{(DATA_W-8){1'b0}}, dd_prev_q[7:0]};
      end else begin : g_plain
         assign narrow_c = dd_prev_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_valid <= 1'b0;
         ev_kind  <= RK_NONE;
         ev_addr  <= '0;
         ev_data  <= '0;
      end else begin
         ev_valid <= release_seen && (kind_c != RK_NONE);
         if (release_seen && (kind_c != RK_NONE)) begin
            ev_kind <= kind_c;
            ev_addr <= {cs1_prev_q, cs0_prev_q, da_prev_q};
            ev_data <= (kind_c == RK_DATA) ? dd_prev_q : narrow_c;
         end
      end
   end

   // R10: one release yields exactly one event, never two in a row
   p_single_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |=> !ev_valid);

   // R9: an event always carries a selected register
   p_kind_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> ev_kind != RK_NONE);

endmodule

// File: rtl/ata_snoop_capture.sv
module ata_snoop_capture
   import ata_snoop_pkg::*;
#(
   parameter int         DATA_W     = 16,
   parameter int         PW_BYTES   = 32,
   parameter int         SKIP_WORDS = 1,
   parameter bit         LOW_FIRST  = 1'b1,
   parameter logic [7:0] UNLOCK_OP  = 8'hF2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ev_valid,
   input  reg_kind_e             ev_kind,
   input  logic [DATA_W-1:0]     ev_data,
   output logic [PW_BYTES*8-1:0] password,
   output logic                  password_valid
);

   localparam int BPW   = DATA_W / 8;
   localparam int WORDS = PW_BYTES / BPW;
   localparam int CNT_W = $clog2(WORDS + SKIP_WORDS + 1);
   localparam cap_state_e ARM_STATE = (SKIP_WORDS == 0) ? CAP_COLLECT : CAP_SKIP;

   initial begin
      assert (PW_BYTES % BPW == 0)
         else $error("ata_snoop_capture: PW_BYTES must fill whole words");
      assert (WORDS >= 1) else $error("ata_snoop_capture: need at least one word");
      assert (SKIP_WORDS >= 0) else $error("ata_snoop_capture: SKIP_WORDS negative");
      assert (DATA_W >= 8 && DATA_W % 8 == 0)
         else $error("ata_snoop_capture: DATA_W must be a multiple of 8");
   end

   cap_state_e                     state_q;
   logic [CNT_W-1:0]               cnt_q;
   logic [WORDS-1:0][DATA_W-1:0]   buf_q;
   logic                           commit_q;
   logic [PW_BYTES*8-1:0]          assembled;

   logic is_data, is_cmd, is_op;
   assign is_data = ev_valid && (ev_kind == RK_DATA);
   assign is_cmd  = ev_valid && (ev_kind == RK_CMD);
   assign is_op   = is_cmd && (ev_data[7:0] == UNLOCK_OP);

   genvar gw, gb;
   generate
      for (gw = 0; gw < WORDS; gw++) begin : g_word
         for (gb = 0; gb < BPW; gb++) begin : g_byte
            if (LOW_FIRST) begin : g_lo
               assign assembled[(gw*BPW+gb)*8 +: 8] = buf_q[gw][gb*8 +: 8];
            end else begin : g_hi
               assign assembled[(gw*BPW+gb)*8 +: 8] = buf_q[gw][(BPW-1-gb)*8 +: 8];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= CAP_IDLE;
         cnt_q    <= '0;
         commit_q <= 1'b0;
      end else begin
         commit_q <= 1'b0;
         if (is_cmd) begin
            cnt_q   <= '0;
            state_q <= is_op ? ARM_STATE : CAP_IDLE;
         end else if (is_data) begin
            unique case (state_q)
               CAP_SKIP: begin
                  if (cnt_q == CNT_W'(SKIP_WORDS - 1)) begin
                     cnt_q   <= '0;
                     state_q <= CAP_COLLECT;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               CAP_COLLECT: begin
                  if (cnt_q == CNT_W'(WORDS - 1)) begin
                     cnt_q    <= '0;
                     state_q  <= CAP_IDLE;
                     commit_q <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_q <= '0;
      end else if (is_data && state_q == CAP_COLLECT) begin
         buf_q[cnt_q[$clog2(WORDS > 1 ? WORDS : 2)-1:0]] <= ev_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         password       <= '0;
         password_valid <= 1'b0;
      end else begin
         password_valid <= commit_q;
         if (commit_q) password <= assembled;
      end
   end

   // R4: completion is a single-cycle pulse
   p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      password_valid |=> !password_valid);

   // R3: collection index never runs past the password length
   p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == CAP_COLLECT |-> cnt_q < CNT_W'(WORDS));

   // R5: a foreign opcode sends the capture back to idle
   p_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_cmd && !is_op) |=> state_q == CAP_IDLE);

   // R6: writes to other registers leave capture progress untouched
   p_aux_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == RK_AUX) |=> ($stable(state_q) && $stable(cnt_q)));

endmodule

// File: rtl/ata_unlock_sniffer.sv
module ata_unlock_sniffer
   import ata_snoop_pkg::*;
#(
   parameter int         DATA_W      = 16,
   parameter int         PW_BYTES    = 32,
   parameter int         SKIP_WORDS  = 1,
   parameter int         SYNC_STAGES = 2,
   parameter bit         LOW_FIRST   = 1'b1,
   parameter logic [7:0] UNLOCK_OP   = 8'hF2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [DATA_W-1:0]     dd,
   input  logic                  cs0_n,
   input  logic                  cs1_n,
   input  logic [2:0]            da,
   input  logic                  diow_n,
   input  logic                  dior_n,
   output logic [PW_BYTES*8-1:0] password,
   output logic                  password_valid,
   output logic [ADDR_W-1:0]     log_addr,
   output logic [DATA_W-1:0]     log_data,
   output logic                  log_valid
);

   localparam int BUS_W = DATA_W + 7;
   localparam logic [BUS_W-1:0] BUS_IDLE = {{DATA_W{1'b0}}, 1'b1, 1'b1, 3'b000, 1'b1, 1'b1};

   logic [BUS_W-1:0]  bus_raw, bus_s;
   logic [DATA_W-1:0] dd_s;
   logic              cs1_n_s, cs0_n_s, diow_n_s, dior_n_s;
   logic [2:0]        da_s;

   assign bus_raw = {dd, cs1_n, cs0_n, da, diow_n, dior_n};
   assign {dd_s, cs1_n_s, cs0_n_s, da_s, diow_n_s, dior_n_s} = bus_s;

   ata_snoop_sync #(
      .W         (BUS_W),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (BUS_IDLE)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (bus_raw),
      .d_sync  (bus_s)
   );

   logic              ev_valid;
   reg_kind_e         ev_kind;
   logic [ADDR_W-1:0] ev_addr;
   logic [DATA_W-1:0] ev_data;

   ata_snoop_decode #(
      .DATA_W (DATA_W)
   ) i_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .dd_s     (dd_s),
      .cs1_n_s  (cs1_n_s),
      .cs0_n_s  (cs0_n_s),
      .da_s     (da_s),
      .diow_n_s (diow_n_s),
      .dior_n_s (dior_n_s),
      .ev_valid (ev_valid),
      .ev_kind  (ev_kind),
      .ev_addr  (ev_addr),
      .ev_data  (ev_data)
   );

   ata_snoop_capture #(
      .DATA_W     (DATA_W),
      .PW_BYTES   (PW_BYTES),
      .SKIP_WORDS (SKIP_WORDS),
      .LOW_FIRST  (LOW_FIRST),
      .UNLOCK_OP  (UNLOCK_OP)
   ) i_capture (
      .clk            (clk),
      .rst_n          (rst_n),
      .ev_valid       (ev_valid),
      .ev_kind        (ev_kind),
      .ev_data        (ev_data),
      .password       (password),
      .password_valid (password_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_addr  <= '0;
         log_data  <= '0;
         log_valid <= 1'b0;
      end else if (ev_valid) begin
         log_addr  <= ev_addr;
         log_data  <= ev_data;
         log_valid <= 1'b1;
      end
   end

   // R8: a completed password was closed by a data-register write
   p_valid_log_r8: assert property (@(posedge clk) disable iff (!rst_n)
      password_valid |-> (log_valid && log_addr == {1'b1, 1'b0, DA_DATA}));

   // R4: password output moves only together with the valid pulse
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !password_valid |-> $stable(password));

   // R8: narrow registers never log an upper byte
   p_narrow_log_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (log_valid && log_addr != {1'b1, 1'b0, DA_DATA}) |-> log_data[DATA_W-1:8] == '0);

endmodule

// File: tb/test_ata_unlock_sniffer.sv
module test_ata_unlock_sniffer;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [15:0]  dd = '0;
   logic         cs0_n = 1'b1, cs1_n = 1'b1, diow_n = 1'b1, dior_n = 1'b1;
   logic [2:0]   da = '0;
   logic [255:0] password;
   logic         password_valid;
   logic [4:0]   log_addr;
   logic [15:0]  log_data;
   logic         log_valid;

   always #10 clk = ~clk;   // 20 ns period, 50 MHz

   ata_unlock_sniffer i_ata_unlock_sniffer (
      .clk(clk), .rst_n(rst_n), .dd(dd), .cs0_n(cs0_n), .cs1_n(cs1_n), .da(da),
      .diow_n(diow_n), .dior_n(dior_n), .password(password),
      .password_valid(password_valid), .log_addr(log_addr), .log_data(log_data),
      .log_valid(log_valid));

   int n_run = 0, n_fail = 0;
   int pulses = 0, hi_cycles = 0;
   logic prev_v = 1'b0;
   logic [255:0] cap_pw = '0;
   bit done = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (password_valid) begin
            hi_cycles++;
            cap_pw = password;
         end
         if (password_valid && !prev_v) pulses++;
         prev_v = password_valid;
      end
   end

   task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pb(input int seed, input int i);
      return 8'((seed * 37 + i * 11 + 92) ^ (i << 3));
   endfunction

   function automatic logic [255:0] exp_pw(input int seed);
      logic [255:0] r;
      for (int i = 0; i < 32; i++) r[8*i +: 8] = pb(seed, i);
      return r;
   endfunction

   task automatic bus_write(input logic c1, input logic c0, input logic [2:0] a,
                            input logic [15:0] v);
      @(negedge clk); cs1_n = c1; cs0_n = c0; da = a; dd = v;
      repeat (2) @(negedge clk); diow_n = 1'b0;
      repeat (3) @(negedge clk); diow_n = 1'b1;
      repeat (4) @(negedge clk); cs1_n = 1'b1; cs0_n = 1'b1; da = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic bus_read(input logic [2:0] a);
      @(negedge clk); cs1_n = 1'b1; cs0_n = 1'b0; da = a; dd = 16'hDEAD;
      repeat (2) @(negedge clk); dior_n = 1'b0;
      repeat (3) @(negedge clk); dior_n = 1'b1;
      repeat (4) @(negedge clk); cs1_n = 1'b1; cs0_n = 1'b1; da = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic overlapped_write(input logic [2:0] a, input logic [15:0] v);
      @(negedge clk); cs1_n = 1'b1; cs0_n = 1'b0; da = a; dd = v; dior_n = 1'b0;
      repeat (2) @(negedge clk); diow_n = 1'b0;
      repeat (3) @(negedge clk); diow_n = 1'b1;
      repeat (4) @(negedge clk); dior_n = 1'b1; cs1_n = 1'b1; cs0_n = 1'b1; da = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic data_word(input int seed, input int k);
      bus_write(1'b1, 1'b0, 3'b000, {pb(seed, 2*k+1), pb(seed, 2*k)});
   endtask

   task automatic opcode(input logic [7:0] op, input logic [7:0] upper);
      bus_write(1'b1, 1'b0, 3'b111, {upper, op});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int p0;
      logic [4:0]  la;
      logic [15:0] ld;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 valid", {255'd0, password_valid}, 256'd0);
      check("R1 password", password, 256'd0);
      check("R1 log", {234'd0, log_valid, log_addr, log_data}, 256'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R8/R9: exhaustive sweep of selects and address lines
      for (int a = 0; a < 32; a++) begin
         logic [15:0] v;
         v  = 16'hA500 | 16'(a);
         la = log_addr; ld = log_data;
         bus_write(a[4], a[3], a[2:0], v);
         repeat (2) @(negedge clk);
         if (a[4] == a[3]) begin
            check("R9 unselected addr", {251'd0, log_addr}, {251'd0, la});
            check("R9 unselected data", {240'd0, log_data}, {240'd0, ld});
         end else begin
            check("R8 log addr", {251'd0, log_addr}, 256'(a));
            check("R8 log data", {240'd0, log_data},
                  (a == 5'b10000) ? 256'(v) : 256'(v[7:0]));
            check("R8 log valid", {255'd0, log_valid}, 256'd1);
         end
      end

      // R2/R3/R4/R6/R7: captures for several passwords
      for (int s = 0; s < 6; s++) begin
         p0 = pulses;
         opcode(8'hF2, 8'(s * 29 + 3));
         bus_write(1'b1, 1'b0, 3'b000, 16'h00C4);   // control word, discarded
         for (int k = 0; k < 16; k++) begin
            data_word(s, k);
            if (s[0] && k == 7) begin
               bus_write(1'b1, 1'b0, 3'b010, 16'h0001);
               bus_write(1'b0, 1'b1, 3'b110, 16'h0004);
               bus_read(3'b000);
               bus_read(3'b111);
            end
         end
         repeat (4) @(negedge clk);
         check("R4 one pulse", 256'(pulses), 256'(p0 + 1));
         check("R3 assembled", cap_pw, exp_pw(s));
         check("R4 held", password, exp_pw(s));
         check("R4 width", 256'(hi_cycles), 256'(pulses));
         check("R8 last data", {251'd0, log_addr}, 256'h10);
      end

      // R5: foreign opcode cancels capture
      p0 = pulses;
      opcode(8'hF2, 8'h00);
      bus_write(1'b1, 1'b0, 3'b000, 16'h0000);
      for (int k = 0; k < 5; k++) data_word(9, k);
      opcode(8'hEC, 8'h00);
      for (int k = 0; k < 16; k++) data_word(9, k);
      repeat (4) @(negedge clk);
      check("R5 abort no pulse", 256'(pulses), 256'(p0));
      check("R5 abort keeps pw", password, exp_pw(5));

      // R5: unlock opcode mid-capture restarts
      p0 = pulses;
      opcode(8'hF2, 8'h11);
      bus_write(1'b1, 1'b0, 3'b000, 16'h0000);
      for (int k = 0; k < 3; k++) data_word(7, k);
      opcode(8'hF2, 8'h22);
      bus_write(1'b1, 1'b0, 3'b000, 16'hFFFF);
      for (int k = 0; k < 16; k++) data_word(8, k);
      repeat (4) @(negedge clk);
      check("R5 restart pulse", 256'(pulses), 256'(p0 + 1));
      check("R5 restart pw", password, exp_pw(8));

      // R5: data words while idle
      p0 = pulses;
      for (int k = 0; k < 17; k++) data_word(10, k % 16);
      repeat (4) @(negedge clk);
      check("R5 idle no pulse", 256'(pulses), 256'(p0));
      check("R5 idle pw kept", password, exp_pw(8));

      // R7: write release during an asserted read is ignored
      la = log_addr; ld = log_data;
      overlapped_write(3'b011, 16'h0077);
      repeat (2) @(negedge clk);
      check("R7 overlap addr", {251'd0, log_addr}, {251'd0, la});
      check("R7 overlap data", {240'd0, log_data}, {240'd0, ld});

      // R10: one write gives one logged value, taken from held bus
      bus_write(1'b1, 1'b0, 3'b100, 16'h1234);
      repeat (2) @(negedge clk);
      check("R10 sampled value", {240'd0, log_data}, 256'h34);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule